// File: doc/BRIEF.md
# Supply Under-Voltage Flag Controller

This block records under-voltage events on three supplies: a 3.3 V rail, the core rail and an analog rail. A detector comparator outside the block raises a level for each rail while that rail is too low. The block passes each level through a two-flop synchroniser and captures it in a sticky flag. The flag stays set until software clears it.

Software reads the flags in a 32-bit status word. Each flag has its own write-one-to-clear bit in a separate clear word. The flags cannot be written directly. An enable word holds an interrupt enable and a reset enable for each rail. A flag combined with its interrupt enable raises the low-voltage interrupt. A flag combined with its reset enable produces a one-cycle system-reset request. The chip reset logic routes that request back to the block's reset input. That reset clears the flags and so withdraws the interrupt.

Supply index order is fixed throughout: index 0 is the 3.3 V rail, index 1 is the core rail and index 2 is the analog rail.

Top module: `lvf_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, all flags, interrupt enables and reset enables are cleared. Afterwards `lv_irq` and `sys_rst_req` are 0 and every register reads zero.
- R2: A read of address 0x0 (status) returns these bits:
  - bit 27 is the 3.3 V flag, bit 28 is the core flag and bit 29 is the analog flag.
  - A flag reads 1 after an occurrence and 0 when none occurred.
  - All other bits read 0, including bits 30 and 31.
- R3: A set flag stays set after its detector input returns low, until a clear or a reset removes it.
- R4: Each detector input `det_lv[i]` is active high and passes two synchroniser flops. If the input is high at rising edge k, flag i reads 1 after edge k+2 and still reads 0 after edge k+1.
- R5: Clearing works through the clear register:
  - A write to address 0x8 (clear) with bit i = 1 clears flag i at that edge. Bit 0 is the 3.3 V rail, bit 1 the core rail and bit 2 the analog rail.
  - Writing 0 to a clear bit leaves the flag unchanged.
  - If the synchronised detector level for rail i is high in the cycle of the clear, the flag stays set.
- R6: A write to the status address 0x0 changes no flag.
- R7: Address 0x4 (enable) holds the per-rail enables and reads them back:
  - Bits [2:0] are the per-rail interrupt enables and bits [10:8] are the per-rail reset enables. All other bits read 0.
  - `lv_irq` is combinationally the OR over the rails of flag AND interrupt enable.
- R8: `sys_rst_req` is a registered pulse of exactly one cycle.
  - It rises one cycle after any flag first coincides with its reset enable.
  - It does not pulse again while that condition stays true.
- R9: When `sys_rst_req` is fed back into `rst`, the resulting reset clears the flags and the enables, and `lv_irq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (system reset) |
| det_lv | input | 3 | Asynchronous under-voltage levels from the comparators, one per rail |
| addr | input | 4 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| lv_irq | output | 1 | Low-voltage interrupt request |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with its default parameters: three rails, a two-stage synchroniser, status flags starting at bit 27 and a 32-bit data word. With these values the exact two-edge latency from detector to flag can be observed at the ports. So can the bit-27-to-29 placement and the race between a clear and a set on the same rail. The reset request is looped back into the reset input only for the last scenario. That scenario shows a self-generated reset wiping the flags, the enables and the interrupt.

// File: rtl/lvf_pkg.sv
package lvf_pkg;

    localparam int SUP_N       = 3;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int FLAG_LSB    = 27;
    localparam int IEN_LSB     = 0;
    localparam int REN_LSB     = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 4'h8;

    typedef logic [SUP_N-1:0] sup_vec_t;

    typedef struct packed {
        sup_vec_t irq_en;
        sup_vec_t rst_en;
    } enables_t;

    typedef enum logic [1:0] {
        SEL_STATUS,
        SEL_ENABLE,
        SEL_CLEAR,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: return SEL_STATUS;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_CLEAR:  return SEL_CLEAR;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lvf_sync.sv
module lvf_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lvf_flag_bank.sv
module lvf_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_lvl,
    input  logic [N-1:0] clr_hit,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            logic flag_q;

            always_ff @(posedge clk) begin
                if (rst)             flag_q <= 1'b0;
                else if (set_lvl[i]) flag_q <= 1'b1;
                else if (clr_hit[i]) flag_q <= 1'b0;
            end

            assign flags[i] = flag_q;

            // R3: a flag only falls through a clear
            a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
                (flag_q && !clr_hit[i]) |=> flag_q);

            // R5: a simultaneous set overrides a clear
            a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
                set_lvl[i] |=> flag_q);

            // R5: a clear with no pending set empties the flag
            a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
                (clr_hit[i] && !set_lvl[i]) |=> !flag_q);

            // R1: reset empties the flag
            a_r1_reset_clears: assert property (@(posedge clk)
                rst |=> !flag_q);
        end
    endgenerate
endmodule

// File: rtl/lvf_req_gen.sv
module lvf_req_gen
    import lvf_pkg::*;
#(
    parameter int N = SUP_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] rst_en,
    output logic         irq,
    output logic         rst_req
);
    logic rst_cond;
    logic cond_q;
    logic req_q;

    assign irq      = |(flags & irq_en);
    assign rst_cond = |(flags & rst_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            cond_q <= rst_cond;
            req_q  <= rst_cond & ~cond_q;
        end
    end

    assign rst_req = req_q;

    // R8: the request never lasts two cycles
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7: no interrupt without a set flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
endmodule

// File: rtl/lvf_ctrl.sv
module lvf_ctrl
    import lvf_pkg::*;
#(
    parameter int N       = SUP_N,
    parameter int STAGES  = SYNC_STAGES,
    parameter int DW      = DATA_W,
    parameter int AW      = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  det_lv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    output logic [DW-1:0] rdata,
    output logic          lv_irq,
    output logic          sys_rst_req
);
    localparam int RSVD_LSB = FLAG_LSB + N;

    logic [N-1:0] det_s;
    logic [N-1:0] flags;
    logic [N-1:0] clr_hit;
    enables_t     en_q;
    reg_sel_e     sel;

    assign sel     = decode_addr(addr);
    assign clr_hit = (wr_en && sel == SEL_CLEAR) ? wdata[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && sel == SEL_ENABLE) begin
            en_q.irq_en <= wdata[IEN_LSB +: N];
            en_q.rst_en <= wdata[REN_LSB +: N];
        end
    end

    lvf_sync #(.WIDTH(N), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (det_lv),
        .sync_out (det_s)
    );

    lvf_flag_bank #(.N(N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_lvl (det_s),
        .clr_hit (clr_hit),
        .flags   (flags)
    );

    lvf_req_gen #(.N(N)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .irq_en  (en_q.irq_en),
        .rst_en  (en_q.rst_en),
        .irq     (lv_irq),
        .rst_req (sys_rst_req)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: rdata[FLAG_LSB +: N] = flags;
            SEL_ENABLE: begin
                rdata[IEN_LSB +: N] = en_q.irq_en;
                rdata[REN_LSB +: N] = en_q.rst_en;
            end
            default: rdata = '0;
        endcase
    end

    // R2: the top bits above the flags stay zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[DW-1:RSVD_LSB] == '0);

    // R6: a status write cannot remove any flag
    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_STATUS) |=> ((flags & $past(flags)) == $past(flags)));

    // R9: a requested reset looped back leaves no interrupt behind
    a_r9_reset_drops_irq: assert property (@(posedge clk)
        rst |=> !lv_irq);
endmodule

// File: tb/tb_lvf_ctrl.sv
`timescale 1ns/1ps
module tb_lvf_ctrl;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        loop_en = 1'b0;
    logic [2:0]  det = '0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    wire  [31:0] rdata;
    wire         irq;
    wire         req;
    wire         rst = por | (loop_en & req);

    always #2.5 clk = ~clk;

    lvf_ctrl dut (
        .clk (clk), .rst (rst), .det_lv (det), .addr (addr),
        .wdata (wdata), .wr_en (wr_en), .rdata (rdata),
        .lv_irq (irq), .sys_rst_req (req)
    );

    int checks = 0;
    int errors = 0;
    int req_count = 0;

    // behavioural reference
    bit [2:0] m_flag, m_ien, m_ren;
    bit       m_cond_prev, m_req;
    bit [2:0] m_pipe [$];
    bit       started = 0;

    function automatic bit [31:0] exp_rd(input bit [3:0] a);
        bit [31:0] v = '0;
        if (a == 4'h0) v[29:27] = m_flag;
        else if (a == 4'h4) begin v[2:0] = m_ien; v[10:8] = m_ren; end
        return v;
    endfunction

    always @(posedge clk) begin
        bit [2:0] nf;
        bit       cond;
        started = 1;
        if (rst) begin
            m_flag = '0; m_ien = '0; m_ren = '0;
            m_cond_prev = 0; m_req = 0;
            m_pipe = '{3'b0, 3'b0};
        end else begin
            nf = m_pipe[0];
            for (int i = 0; i < 3; i++)
                if (m_flag[i] && !(wr_en && addr == 4'h8 && wdata[i])) nf[i] = 1'b1;
            cond = |(m_flag & m_ren);
            m_req = cond && !m_cond_prev;
            m_cond_prev = cond;
            if (wr_en && addr == 4'h4) begin
                m_ien = wdata[2:0];
                m_ren = wdata[10:8];
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(det);
            m_flag = nf;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R7 lv_irq per-cycle", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
            chk("R8 sys_rst_req per-cycle", {31'b0, req}, {31'b0, m_req});
            chk("R2 rdata per-cycle", rdata, exp_rd(addr));
            if (req) req_count++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        @(negedge clk); #1 addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); #1 wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input bit [3:0] a, input string tag, input bit [31:0] exp);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        cyc(3);
        #1 por = 1'b0;
        cyc(1);
        rd_chk(4'h0, "R1 status after reset", 32'h0);
        rd_chk(4'h4, "R1 enable after reset", 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R4 latency: high before one edge only
        @(negedge clk); #1 det = 3'b001; addr = 4'h0;
        @(negedge clk); #1 det = 3'b000;
        chk("R4 flag not yet after first edge", rdata, 32'h0);
        cyc(1);
        chk("R4 flag not yet after second edge", rdata, 32'h0);
        cyc(1);
        chk("R4 flag after third edge", rdata, 32'h0800_0000);
        cyc(6);
        chk("R3 flag sticky", rdata, 32'h0800_0000);

        wr(4'h0, 32'h0);
        rd_chk(4'h0, "R6 status write of zeros ignored", 32'h0800_0000);
        wr(4'h8, 32'h0);
        rd_chk(4'h0, "R5 clear with zero keeps flag", 32'h0800_0000);
        wr(4'h8, 32'h1);
        rd_chk(4'h0, "R5 clear bit0 empties 3.3V flag", 32'h0);

        // R5 set wins while the core detector holds low-voltage
        @(negedge clk); #1 det = 3'b010;
        cyc(4);
        wr(4'h8, 32'h2);
        rd_chk(4'h0, "R5 set wins over clear", 32'h1000_0000);
        @(negedge clk); #1 det = 3'b000;
        cyc(4);
        wr(4'h8, 32'h2);
        rd_chk(4'h0, "R5 clear after detector quiet", 32'h0);

        // R7 enables and interrupt
        wr(4'h4, 32'hFFFF_F702);
        rd_chk(4'h4, "R7 enable readback", 32'h0000_0702);
        chk("R7 irq low with no flag", {31'b0, irq}, 32'h0);
        @(negedge clk); #1 det = 3'b010;
        @(negedge clk); #1 det = 3'b000;
        cyc(2);
        chk("R7 irq from core flag", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h2);
        chk("R7 irq drops on clear", {31'b0, irq}, 32'h0);

        // R8 single pulse from the analog rail (reset enable bit 10)
        req_count = 0;
        @(negedge clk); #1 det = 3'b100;
        cyc(12);
        chk("R8 one pulse while condition holds", req_count, 1);
        rd_chk(4'h0, "R2 analog flag at bit 29", 32'h2000_0000);
        @(negedge clk); #1 det = 3'b000;
        cyc(3);
        wr(4'h8, 32'h7);

        // R9 loop the request back into reset
        wr(4'h4, 32'h0000_0101);
        loop_en = 1'b1;
        @(negedge clk); #1 det = 3'b001;
        @(negedge clk); #1 det = 3'b000;
        cyc(6);
        rd_chk(4'h0, "R9 flags cleared by own reset", 32'h0);
        rd_chk(4'h4, "R9 enables cleared by own reset", 32'h0);
        chk("R9 irq withdrawn", {31'b0, irq}, 32'h0);
        loop_en = 1'b0;
        cyc(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule